// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the configuration registers of a single-vector message-signalled-interrupt capability. Software reaches it through a dword-wide configuration port with a dword index inside the capability and four byte enables. The port claims an access only when every enabled byte lies inside the capability. Two elaboration parameters fix the layout: 32-bit or 64-bit message addresses, and whether a per-vector mask and pending pair is present. The length and the writable bits of each dword follow from these two choices.

Alongside the registers, the block reports enable and disable transitions of the capability. While the capability is enabled, it reports every change to the programmed message address or data, and the report carries the new values. When the device raises an interrupt trigger, the block builds one message write request from the programmed address and data. It holds that request on a valid/ready handshake until it is accepted. A trigger that arrives while the vector is masked is recorded in the pending bit and sent once the mask is cleared.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, dword 0 reads {control[15:0], next pointer[7:0], capability ID[7:0]}. The control word has enable, multiple-message-enable and extended-data-enable at zero, and its capability bits come from the parameters. The address, data, mask and pending registers read zero and no request is valid.
- R2: The control word layout is: bit 0 enable, bits 3:1 multiple-message capable, bits 6:4 multiple-message enable, bit 7 64-bit capable, bit 8 per-vector masking, bit 9 extended-data capable, bit 10 extended-data enable. Only bits 0, 6:4 and 10 are writable, which gives a dword-0 write mask of 0x0471_0000.
- R3: The capability is 10 bytes long with 32-bit addresses and no masking, 20 with 32-bit and masking, 14 with 64-bit and no masking, and 24 with 64-bit and masking. cfg_hit is high only for a read or write whose highest enabled byte, at dword index times 4 plus lane, is below the length. An unclaimed write changes nothing and an unclaimed read returns zero.
- R4: The low address is dword 1, and its bits 1:0 always read zero. With 64-bit addressing the high address is dword 2 and the data is dword 3. With 32-bit addressing the data is dword 2 and the high address is zero. The 16-bit message data sits in bits 15:0, and the upper half of that dword reads zero.
- R5: A write changes only the bits that are both writable and inside an enabled byte lane (be[i] covers bits 8i+7:8i).
- R6: A claimed write that takes enable from 0 to 1 pulses evt_enabled for one cycle. A write that takes it from 1 to 0 pulses evt_disabled for one cycle. The pulse is high in the cycle after the write's clock edge.
- R7: While enabled, a write that changes the stored address or data pulses route_upd for one cycle, in the cycle after the write's edge. route_addr and route_data show the new values in that cycle. A write that leaves both unchanged, or any write made while disabled, gives no pulse.
- R8: A trigger while enabled, with the vector unmasked and no request outstanding, raises msg_valid on the next edge. msg_addr then carries the 64-bit address and msg_data carries the data zero-extended to 32 bits. All three hold steady until a cycle with msg_ready high.
- R9: With masking, the mask dword follows the data dword and is fully writable, and the next dword holds the read-only pending bits. A trigger while enabled with mask bit 0 set sets pending bit 0 and sends no request. Clearing the mask while the pending bit is set sends one request on the edge after the mask write, and that request clears the pending bit.
- R10: A trigger while disabled, or while a request is still outstanding, is dropped and produces no later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 3 | Dword index inside the capability |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (combinational) |
| cfg_hit | output | 1 | Access lies inside the capability |
| evt_enabled | output | 1 | One-cycle enable transition pulse |
| evt_disabled | output | 1 | One-cycle disable transition pulse |
| route_upd | output | 1 | One-cycle message-changed pulse |
| route_addr | output | 64 | Programmed message address |
| route_data | output | 16 | Programmed message data |
| irq_trig | input | 1 | Interrupt trigger |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write request accepted |
| msg_addr | output | 64 | Request address |
| msg_data | output | 32 | Request data |

## Verification
Reads are combinational, so cfg_rdata and cfg_hit are sampled one nanosecond after the inputs change, with no clock edge in between. Register contents and the evt_enabled, evt_disabled and route_upd pulses come from the write's clock edge. The bench drives each write at a falling edge, removes it at the next falling edge, and samples the pulses right there, inside their only high cycle. msg_valid rises on the edge after a trigger, or on the second edge after the mask-clearing write for a pending drain. The bench counts those edges at falling-edge sample points before it checks the request fields and their stability.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  typedef struct packed {
    logic ctrl;
    logic alo;
    logic ahi;
    logic data;
    logic mask;
    logic pend;
  } cap_sel_t;

  function automatic logic [5:0] cap_len(input bit a64, input bit msk);
    case ({a64, msk})
      2'b00:   return 6'd10;
      2'b01:   return 6'd20;
      2'b10:   return 6'd14;
      default: return 6'd24;
    endcase
  endfunction

  function automatic logic [31:0] be_bits(input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = {8{be[i]}};
    return r;
  endfunction

  function automatic logic [1:0] top_lane(input logic [3:0] be);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 0; i < 4; i++) if (be[i]) r = 2'(i);
    return r;
  endfunction

  function automatic logic [31:0] wr_mask(input logic [2:0] idx, input bit a64, input bit msk);
    case (idx)
      3'd0: return 32'h0471_0000;
      3'd1: return 32'hFFFF_FFFC;
      3'd2: return a64 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      3'd3: return a64 ? 32'h0000_FFFF : (msk ? 32'hFFFF_FFFF : 32'h0);
      3'd4: return (a64 && msk) ? 32'hFFFF_FFFF : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [31:0] m);
    return (old & ~m) | (nw & m);
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64  = 1'b1,
  parameter bit MASKING = 1'b1
) (
  input  logic           cfg_wr,
  input  logic           cfg_rd,
  input  logic [2:0]     cfg_idx,
  input  logic [3:0]     cfg_be,
  output logic           hit,
  output cap_sel_t       sel,
  output logic [31:0]    wmask
);
  localparam logic [5:0] LEN      = cap_len(ADDR64, MASKING);
  localparam logic [2:0] IDX_DATA = ADDR64 ? 3'd3 : 3'd2;
  localparam logic [2:0] IDX_MASK = IDX_DATA + 3'd1;
  localparam logic [2:0] IDX_PEND = IDX_DATA + 3'd2;

  logic [5:0] last_byte;
  assign last_byte = {1'b0, cfg_idx, 2'b00} + {4'b0, top_lane(cfg_be)};
  assign hit = (cfg_wr | cfg_rd) && (last_byte < LEN);

  always_comb begin
    sel.ctrl = (cfg_idx == 3'd0);
    sel.alo  = (cfg_idx == 3'd1);
    sel.ahi  = ADDR64 && (cfg_idx == 3'd2);
    sel.data = (cfg_idx == IDX_DATA);
    sel.mask = MASKING && (cfg_idx == IDX_MASK);
    sel.pend = MASKING && (cfg_idx == IDX_PEND);
  end

  assign wmask = (cfg_wr && hit) ? (wr_mask(cfg_idx, ADDR64, MASKING) & be_bits(cfg_be)) : 32'h0;

endmodule

// File: rtl/msi_cap_regfile.sv
module msi_cap_regfile
  import msi_cap_pkg::*;
#(
  parameter bit         ADDR64   = 1'b1,
  parameter bit         MASKING  = 1'b1,
  parameter logic [2:0] MMC      = 3'd0,
  parameter logic [7:0] CAP_ID   = 8'h05,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  cap_sel_t    sel,
  input  logic        hit,
  input  logic [31:0] wmask,
  input  logic [31:0] wdata,
  input  logic        pend,
  output logic [31:0] rdata,
  output logic        en,
  output logic        mask0,
  output logic [63:0] addr,
  output logic [15:0] data,
  output logic        evt_enabled,
  output logic        evt_disabled,
  output logic        route_upd
);
  logic        en_q, xen_q;
  logic [2:0]  mme_q;
  logic [31:0] alo_q, ahi_q, msk_q;
  logic [15:0] dat_q;
  logic [15:0] ctrl_w;
  logic [31:0] dw0, d0_n, alo_n, ahi_n, dat_w, msk_n;
  logic        chg;

  assign ctrl_w = {5'b0, xen_q, 1'b0, MASKING, ADDR64, mme_q, MMC, en_q};
  assign dw0    = {ctrl_w, NEXT_PTR, CAP_ID};

  always_comb begin
    d0_n  = merge(dw0, wdata, sel.ctrl ? wmask : 32'h0);
    alo_n = merge(alo_q, wdata, sel.alo ? wmask : 32'h0);
    dat_w = merge({16'h0, dat_q}, wdata, sel.data ? wmask : 32'h0);
    msk_n = merge(msk_q, wdata, sel.mask ? wmask : 32'h0);
    chg   = (alo_n != alo_q) || (ahi_n != ahi_q) || (dat_w[15:0] != dat_q);
  end

  generate
    if (ADDR64) begin : g_hi
      always_comb ahi_n = merge(ahi_q, wdata, sel.ahi ? wmask : 32'h0);
      always_ff @(posedge clk) begin
        if (!rst_n) ahi_q <= '0;
        else        ahi_q <= ahi_n;
      end
    end else begin : g_no_hi
      assign ahi_n = '0;
      assign ahi_q = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; xen_q <= 1'b0; mme_q <= '0;
      alo_q <= '0; dat_q <= '0; msk_q <= '0;
      evt_enabled <= 1'b0; evt_disabled <= 1'b0; route_upd <= 1'b0;
    end else begin
      en_q  <= d0_n[16];
      mme_q <= d0_n[22:20];
      xen_q <= d0_n[26];
      alo_q <= alo_n;
      dat_q <= dat_w[15:0];
      msk_q <= msk_n;
      evt_enabled  <= d0_n[16] & ~en_q;
      evt_disabled <= ~d0_n[16] & en_q;
      route_upd    <= d0_n[16] & chg;
    end
  end

  always_comb begin
    rdata = 32'h0;
    if (hit) begin
      if (sel.ctrl)      rdata = dw0;
      else if (sel.alo)  rdata = alo_q;
      else if (sel.ahi)  rdata = ahi_q;
      else if (sel.data) rdata = {16'h0, dat_q};
      else if (sel.mask) rdata = msk_q;
      else if (sel.pend) rdata = {31'h0, pend};
    end
  end

  assign en    = en_q;
  assign mask0 = msk_q[0];
  assign addr  = {ahi_q, alo_q};
  assign data  = dat_q;

  p_evt_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_enabled |-> (en_q && !$past(en_q)));
  p_evt_dis_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_disabled |-> (!en_q && $past(en_q)));
  p_route_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    route_upd |-> en_q);
  p_route_chg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    route_upd |-> (addr != $past(addr) || data != $past(data)));
endmodule

// File: rtl/msi_cap_msg.sv
module msi_cap_msg #(
  parameter bit MASKING = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig,
  input  logic        en,
  input  logic        mask0,
  input  logic [63:0] addr,
  input  logic [15:0] data,
  input  logic        ready,
  output logic        valid,
  output logic [63:0] maddr,
  output logic [31:0] mdata,
  output logic        pend
);
  logic masked, issue, pend_set;

  assign masked   = MASKING && mask0;
  assign issue    = en && !valid && !masked && (trig || pend);
  assign pend_set = MASKING && en && trig && mask0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0; maddr <= '0; mdata <= '0;
    end else begin
      valid <= issue || (valid && !ready);
      if (issue) begin
        maddr <= addr;
        mdata <= {16'h0, data};
      end
    end
  end

  generate
    if (MASKING) begin : g_pend
      always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= pend_set || (pend && !issue);
      end
      p_pend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(trig && mask0 && en));
    end else begin : g_no_pend
      assign pend = 1'b0;
    end
  endgenerate

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(maddr) && $stable(mdata)));
  p_issue_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(en));
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !valid);
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter bit         ADDR64   = 1'b1,
  parameter bit         MASKING  = 1'b1,
  parameter logic [2:0] MMC      = 3'd0,
  parameter logic [7:0] CAP_ID   = 8'h05,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [2:0]  cfg_idx,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_hit,
  output logic        evt_enabled,
  output logic        evt_disabled,
  output logic        route_upd,
  output logic [63:0] route_addr,
  output logic [15:0] route_data,
  input  logic        irq_trig,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);
  cap_sel_t    sel;
  logic [31:0] wmask;
  logic        en, mask0, pend;

  msi_cap_decode #(.ADDR64(ADDR64), .MASKING(MASKING)) u_dec (
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
    .hit(cfg_hit), .sel(sel), .wmask(wmask));

  msi_cap_regfile #(.ADDR64(ADDR64), .MASKING(MASKING), .MMC(MMC),
                    .CAP_ID(CAP_ID), .NEXT_PTR(NEXT_PTR)) u_rf (
    .clk(clk), .rst_n(rst_n), .sel(sel), .hit(cfg_hit), .wmask(wmask),
    .wdata(cfg_wdata), .pend(pend), .rdata(cfg_rdata), .en(en), .mask0(mask0),
    .addr(route_addr), .data(route_data), .evt_enabled(evt_enabled),
    .evt_disabled(evt_disabled), .route_upd(route_upd));

  msi_cap_msg #(.MASKING(MASKING)) u_msg (
    .clk(clk), .rst_n(rst_n), .trig(irq_trig), .en(en), .mask0(mask0),
    .addr(route_addr), .data(route_data), .ready(msg_ready), .valid(msg_valid),
    .maddr(msg_addr), .mdata(msg_data), .pend(pend));

  p_unclaimed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_hit) |=> ($stable(route_addr) && $stable(route_data)));
endmodule

// File: tb/test_msi_cap_regs.sv
module test_msi_cap_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_wr = 0, cfg_rd = 0, irq_trig = 0, msg_ready = 0;
  logic [2:0]  cfg_idx = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata, msg_data;
  logic        cfg_hit, evt_enabled, evt_disabled, route_upd, msg_valid;
  logic [63:0] route_addr, msg_addr;
  logic [15:0] route_data;

  logic        b_wr = 0, b_rd = 0;
  logic [2:0]  b_idx = 0;
  logic [3:0]  b_be = 0;
  logic [31:0] b_wdata = 0, b_rdata, b_mdata;
  logic        b_hit, b_en, b_dis, b_route, b_valid;
  logic [63:0] b_raddr, b_maddr;
  logic [15:0] b_rdat;

  int checks = 0, errors = 0;
  bit done = 0;

  msi_cap_regs #(.ADDR64(1'b1), .MASKING(1'b1), .NEXT_PTR(8'h60)) i_msi_cap_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_hit(cfg_hit),
    .evt_enabled(evt_enabled), .evt_disabled(evt_disabled), .route_upd(route_upd),
    .route_addr(route_addr), .route_data(route_data), .irq_trig(irq_trig),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  msi_cap_regs #(.ADDR64(1'b0), .MASKING(1'b0), .NEXT_PTR(8'h60)) i_msi_cap_regs_32 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(b_wr), .cfg_rd(b_rd), .cfg_idx(b_idx),
    .cfg_be(b_be), .cfg_wdata(b_wdata), .cfg_rdata(b_rdata), .cfg_hit(b_hit),
    .evt_enabled(b_en), .evt_disabled(b_dis), .route_upd(b_route),
    .route_addr(b_raddr), .route_data(b_rdat), .irq_trig(1'b0),
    .msg_valid(b_valid), .msg_ready(1'b1), .msg_addr(b_maddr), .msg_data(b_mdata));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
  endtask

  task automatic rd(input logic [2:0] idx, input logic [3:0] be, output logic [31:0] d,
                    output logic h);
    @(negedge clk);
    cfg_rd = 1; cfg_idx = idx; cfg_be = be;
    #1 d = cfg_rdata; h = cfg_hit;
    cfg_rd = 0;
  endtask

  task automatic b_access(input bit w, input logic [2:0] idx, input logic [3:0] be,
                          input logic [31:0] d, output logic [31:0] q, output logic h);
    @(negedge clk);
    b_wr = w; b_rd = !w; b_idx = idx; b_be = be; b_wdata = d;
    #1 q = b_rdata; h = b_hit;
    @(negedge clk);
    b_wr = 0; b_rd = 0;
  endtask

  task automatic trig_pulse();
    @(negedge clk); irq_trig = 1;
    @(negedge clk); irq_trig = 0;
  endtask

  task automatic accept();
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic h;
    rd(3'd0, 4'hF, d, h);
    chk("R1 dword0", d, 32'h0180_6005);
    rd(3'd1, 4'hF, d, h);
    chk("R1 addr lo", d, 0);
    rd(3'd3, 4'hF, d, h);
    chk("R1 data", d, 0);
    chk("R1 no request", msg_valid, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d; logic h;
    wr(3'd0, 4'hF, 32'hFFFF_FFFF);
    chk("R6 enabled pulse", evt_enabled, 1);
    chk("R7 no route on enable", route_upd, 0);
    rd(3'd0, 4'hF, d, h);
    chk("R2 writable ctrl bits", d, 32'h05F1_6005);
    chk("R6 pulse one cycle", evt_enabled, 0);
    wr(3'd0, 4'hF, 32'h0);
    chk("R6 disabled pulse", evt_disabled, 1);
    rd(3'd0, 4'hF, d, h);
    chk("R2 ctrl cleared", d, 32'h0180_6005);
  endtask

  task automatic t_addr();
    logic [31:0] d; logic h;
    wr(3'd1, 4'hF, 32'h0000_0011);
    chk("R7 no route while disabled", route_upd, 0);
    wr(3'd0, 4'b0100, 32'h0001_0000);
    chk("R6 enabled pulse", evt_enabled, 1);
    wr(3'd1, 4'hF, 32'h1234_5677);
    chk("R7 route on addr lo", route_upd, 1);
    chk("R4 R7 route addr", route_addr, 64'h0000_0000_1234_5674);
    wr(3'd2, 4'hF, 32'hAABB_CCDD);
    chk("R7 route on addr hi", route_upd, 1);
    chk("R4 hi half only", route_addr, 64'hAABB_CCDD_1234_5674);
    wr(3'd2, 4'hF, 32'hAABB_CCDD);
    chk("R7 no route on same value", route_upd, 0);
    wr(3'd3, 4'hF, 32'hFFFF_BEEF);
    chk("R7 route on data", route_upd, 1);
    chk("R7 route data", route_data, 16'hBEEF);
    rd(3'd3, 4'hF, d, h);
    chk("R4 data upper zero", d, 32'h0000_BEEF);
    wr(3'd1, 4'b1000, 32'h9900_0000);
    rd(3'd1, 4'hF, d, h);
    chk("R5 byte lane write", d, 32'h9934_5674);
  endtask

  task automatic t_msg();
    trig_pulse();
    chk("R8 valid", msg_valid, 1);
    chk("R8 addr", msg_addr, 64'hAABB_CCDD_9934_5674);
    chk("R8 data", msg_data, 32'h0000_BEEF);
    @(negedge clk); @(negedge clk);
    chk("R8 held", msg_valid, 1);
    chk("R8 addr held", msg_addr, 64'hAABB_CCDD_9934_5674);
    accept();
    chk("R8 released", msg_valid, 0);
  endtask

  task automatic t_drop();
    trig_pulse();
    chk("R8 valid again", msg_valid, 1);
    trig_pulse();
    accept();
    chk("R10 busy trig dropped", msg_valid, 0);
    @(negedge clk);
    chk("R10 busy trig dropped later", msg_valid, 0);
    wr(3'd0, 4'hF, 32'h0);
    chk("R6 disabled pulse", evt_disabled, 1);
    trig_pulse();
    @(negedge clk);
    chk("R10 disabled trig dropped", msg_valid, 0);
    wr(3'd0, 4'hF, 32'h0001_0000);
    @(negedge clk);
    chk("R10 no late request", msg_valid, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d; logic h;
    wr(3'd4, 4'hF, 32'h0000_0001);
    trig_pulse();
    chk("R9 masked no request", msg_valid, 0);
    rd(3'd5, 4'hF, d, h);
    chk("R9 pending set", d, 1);
    wr(3'd5, 4'hF, 32'h0);
    rd(3'd5, 4'hF, d, h);
    chk("R9 pending read-only", d, 1);
    wr(3'd4, 4'hF, 32'h0);
    chk("R9 not before drain edge", msg_valid, 0);
    @(negedge clk);
    chk("R9 drain request", msg_valid, 1);
    rd(3'd5, 4'hF, d, h);
    chk("R9 pending cleared", d, 0);
    accept();
  endtask

  task automatic t_window();
    logic [31:0] d; logic h;
    rd(3'd6, 4'hF, d, h);
    chk("R3 beyond 24 bytes", h, 0);
    rd(3'd5, 4'hF, d, h);
    chk("R3 last dword claimed", h, 1);
    b_access(0, 3'd0, 4'hF, 0, d, h);
    chk("R1 32-bit dword0", d, 32'h0000_6005);
    b_access(1, 3'd1, 4'hF, 32'hFFFF_FFFF, d, h);
    b_access(0, 3'd1, 4'hF, 0, d, h);
    chk("R4 32-bit addr low bits", d, 32'hFFFF_FFFC);
    b_access(1, 3'd2, 4'b1100, 32'hFFFF_FFFF, d, h);
    chk("R3 past 10 bytes unclaimed", h, 0);
    b_access(0, 3'd2, 4'b0011, 0, d, h);
    chk("R3 unclaimed write no effect", d, 0);
    chk("R3 data bytes claimed", h, 1);
    b_access(1, 3'd2, 4'b0011, 32'h5555_1234, d, h);
    b_access(0, 3'd2, 4'b0011, 0, d, h);
    chk("R4 32-bit data dword", d, 32'h0000_1234);
    b_access(0, 3'd3, 4'b0001, 0, d, h);
    chk("R3 no dword3 in 32-bit", h, 0);
    chk("R4 32-bit high addr zero", b_raddr[63:32], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_addr();
    t_msg();
    t_drop();
    t_mask();
    t_window();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule